// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block collects single-bit hardware events into three banks of 32 pending flags, 96 flags in all. It turns them into three level-sensitive interrupt requests of falling priority: high, mid and low. An event source presents a 7-bit event code together with a one-cycle strobe. The upper two code bits pick a bank and the lower five pick the flag inside it. Each flag is sticky: once set, it stays set until software clears it.

Each interrupt line has its own set of three 32-bit enable masks, one mask per bank. A line is raised while any bank holds a pending flag that is enabled in that line's mask for the bank. It falls as soon as no such flag is left. A flat register bus gives access to the pending and mask registers. Reads are combinational and have no side effects. Writes take effect at the clock edge. Pending flags are cleared by writing ones.

The address is four bits wide. Bits 3:2 select a group: 0 for pending, 1 for the high-line masks, 2 for the mid-line masks and 3 for the low-line masks. Bits 1:0 select the bank (0 to 2).

Top module: `evt_agg`

## Requirements
- R1: When the event strobe is high and code bits 6:5 are 0, 1 or 2, that bank's pending flag at the position given by code bits 4:0 is set at the next clock edge.
- R2: Events accumulate. Flags already set stay set when another event arrives in the same or another bank.
- R3: A write to group 1, 2 or 3 (address bits 3:2) with bank index 0 to 2 (bits 1:0) loads the mask of the high, mid or low line for that bank. The mask reads back at the same address. Any address with bank index 3 reads zero, and a write to it changes nothing.
- R4: irq_hi is high when any bank has a pending flag that is set in its high-line mask. irq_mid and irq_lo follow the same rule with their own masks. Each line reflects register state in the cycle after an update.
- R5: A write to group 0 clears exactly the pending flags of the addressed bank that are 1 in the write data. All other flags are unchanged.
- R6: After a clear, a line stays high while any other bank still holds a flag that is enabled for it. It falls only when no enabled flag remains in any bank.
- R7: A read of a pending register returns its current value and changes no state.
- R8: A change to a mask alone, with no new event, raises or lowers the affected line in the next cycle.
- R9: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: An event code with bits 6:5 equal to 3 changes no pending flag.
- R11: Reset clears every pending and mask register and holds all three lines low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_code | input | 7 | Event code: bits 6:5 select the bank, bits 4:0 select the flag |
| reg_addr | input | 4 | Register address: bits 3:2 select the group, bits 1:0 select the bank |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_hi | output | 1 | Highest-priority interrupt request |
| irq_mid | output | 1 | Middle-priority interrupt request |
| irq_lo | output | 1 | Lowest-priority interrupt request |

## Verification
The bench drives an event and a write-one-to-clear onto the same flag in the same cycle. A design that lets the clear win would lose that event. It clears one bank while another bank still holds an enabled flag. A design that drops the line on every clear, or that looks only at the bank just written, would lower the interrupt too early. It changes masks with no events arriving, sends event codes aimed at the non-existent fourth bank, and uses addresses whose bank index is 3. These catch a line that is only re-evaluated when an event comes in, a decoder that aliases bank 3 onto a real bank, and stray writes through the unused addresses.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
    localparam int NBANK   = 3;
    localparam int BANK_W  = 32;
    localparam int CODE_W  = 7;
    localparam int NLINE   = 3;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = $clog2(BANK_W);
    localparam int BIDX_W  = CODE_W - SEL_W;
    localparam int GRP_W   = ADDR_W - BIDX_W;

    typedef enum logic [GRP_W-1:0] {
        GRP_PEND     = 2'd0,
        GRP_MASK_HI  = 2'd1,
        GRP_MASK_MID = 2'd2,
        GRP_MASK_LO  = 2'd3
    } grp_e;
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
    parameter int BANK_W   = 32,
    parameter int CODE_W   = 7,
    parameter int BANK_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              clr_we,
    input  logic [BANK_W-1:0] clr_data,
    output logic [BANK_W-1:0] pend_o
);
    localparam int SEL_W  = $clog2(BANK_W);
    localparam int BIDX_W = CODE_W - SEL_W;

    typedef struct packed {
        logic [BANK_W-1:0] pend;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic [BANK_W-1:0] set_vec;
    logic [BANK_W-1:0] clr_vec;

    always_comb begin
        sel     = evt_code[SEL_W-1:0];
        hit     = evt_valid && (evt_code[CODE_W-1:SEL_W] == BIDX_W'(BANK_IDX));
        set_vec = '0;
        if (hit) set_vec[sel] = 1'b1;
        clr_vec = clr_we ? clr_data : '0;
        // a new event outranks a clear of the same flag
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pend_o[$past(sel)]);

    p_event_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr_we && clr_data[sel]) |=> pend_o[$past(sel)]);

    p_clear_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !hit) |=> ((pend_o & $past(clr_data)) == '0));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/evt_mask_set.sv
module evt_mask_set #(
    parameter int NBANK  = 3,
    parameter int BANK_W = 32,
    parameter int BIDX_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [BIDX_W-1:0]            wr_bank,
    input  logic [BANK_W-1:0]            wr_data,
    output logic [NBANK-1:0][BANK_W-1:0] mask_o
);
    typedef struct packed {
        logic [NBANK-1:0][BANK_W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < NBANK; b++) begin
            if (wr_en && (wr_bank == BIDX_W'(b))) st_d.mask[b] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_o));
endmodule

// File: rtl/evt_line_match.sv
module evt_line_match #(
    parameter int NBANK  = 3,
    parameter int BANK_W = 32
) (
    input  logic [NBANK-1:0][BANK_W-1:0] pend_i,
    input  logic [NBANK-1:0][BANK_W-1:0] mask_i,
    output logic                         irq_o
);
    always_comb begin
        irq_o = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            irq_o = irq_o | (|(pend_i[b] & mask_i[b]));
        end
    end
endmodule

// File: rtl/evt_agg.sv
module evt_agg
    import evt_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [BANK_W-1:0] reg_rdata,
    output logic              irq_hi,
    output logic              irq_mid,
    output logic              irq_lo
);
    logic [GRP_W-1:0]                          grp;
    logic [BIDX_W-1:0]                         bidx;
    logic [NBANK-1:0][BANK_W-1:0]              pend_all;
    logic [NLINE-1:0][NBANK-1:0][BANK_W-1:0]   mask_all;
    logic [NLINE-1:0]                          irq_vec;

    assign grp  = reg_addr[ADDR_W-1:BIDX_W];
    assign bidx = reg_addr[BIDX_W-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        evt_pend_bank #(
            .BANK_W  (BANK_W),
            .CODE_W  (CODE_W),
            .BANK_IDX(b)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_valid(evt_valid),
            .evt_code (evt_code),
            .clr_we   (reg_we && (grp == GRP_PEND) && (bidx == BIDX_W'(b))),
            .clr_data (reg_wdata),
            .pend_o   (pend_all[b])
        );
    end

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        evt_mask_set #(
            .NBANK (NBANK),
            .BANK_W(BANK_W),
            .BIDX_W(BIDX_W)
        ) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (reg_we && (grp == GRP_W'(l + 1))),
            .wr_bank(bidx),
            .wr_data(reg_wdata),
            .mask_o (mask_all[l])
        );

        evt_line_match #(
            .NBANK (NBANK),
            .BANK_W(BANK_W)
        ) u_match (
            .pend_i(pend_all),
            .mask_i(mask_all[l]),
            .irq_o (irq_vec[l])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bidx == BIDX_W'(b)) begin
                if (grp == GRP_PEND) reg_rdata = pend_all[b];
                else                 reg_rdata = mask_all[grp - 1'b1][b];
            end
        end
    end

    assign irq_hi  = irq_vec[0];
    assign irq_mid = irq_vec[1];
    assign irq_lo  = irq_vec[2];

    p_bank3_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code[CODE_W-1:SEL_W] == '1) && !reg_we) |=> $stable(pend_all));

    p_hi_low_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_hi |-> ((pend_all & mask_all[0]) == '0));

    p_lo_high_when_any_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_all & mask_all[2]) != '0) |-> irq_lo);

    p_read_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !evt_valid) |=> $stable(pend_all));

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!irq_hi && !irq_mid && !irq_lo && pend_all == '0));
endmodule

// File: tb/evt_agg_tb.sv
`timescale 1ns/1ps
module evt_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [6:0]  evt_code = '0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_hi, irq_mid, irq_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_pend [3];
    logic [31:0] m_mask [3][3];

    always #2 clk = ~clk;

    evt_agg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq(input int l);
        logic r = 1'b0;
        for (int b = 0; b < 3; b++) r = r | (|(m_pend[b] & m_mask[l][b]));
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        if (a[1:0] == 2'd3) return 32'h0;
        if (a[3:2] == 2'd0) return m_pend[a[1:0]];
        return m_mask[a[3:2] - 1][a[1:0]];
    endfunction

    task automatic chk_irq(input string tag);
        chk({tag, " irq_hi"},  {31'b0, irq_hi},  {31'b0, exp_irq(0)});
        chk({tag, " irq_mid"}, {31'b0, irq_mid}, {31'b0, exp_irq(1)});
        chk({tag, " irq_lo"},  {31'b0, irq_lo},  {31'b0, exp_irq(2)});
    endtask

    // called at a negedge; returns at the following negedge
    task automatic step(input logic ev, input logic [6:0] code, input logic we,
                        input logic [3:0] addr, input logic [31:0] wd, input string tag);
        evt_valid = ev; evt_code = code; reg_we = we; reg_addr = addr; reg_wdata = wd;
        @(posedge clk);
        for (int b = 0; b < 3; b++) begin
            logic [31:0] clr = (we && addr[3:2] == 2'd0 && addr[1:0] == b[1:0]) ? wd : 32'h0;
            logic [31:0] st  = (ev && code[6:5] == b[1:0]) ? (32'h1 << code[4:0]) : 32'h0;
            m_pend[b] = (m_pend[b] & ~clr) | st;
        end
        if (we && addr[3:2] != 2'd0 && addr[1:0] != 2'd3) m_mask[addr[3:2] - 1][addr[1:0]] = wd;
        @(negedge clk);
        evt_valid = 1'b0; reg_we = 1'b0;
        chk_irq(tag);
    endtask

    task automatic rd(input logic [3:0] addr, input string tag);
        reg_addr = addr;
        #0.5;
        chk(tag, reg_rdata, exp_rd(addr));
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd5150);
        for (int b = 0; b < 3; b++) begin
            m_pend[b] = '0;
            for (int l = 0; l < 3; l++) m_mask[l][b] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        chk_irq("R11");
        for (int a = 0; a < 16; a++) rd(a[3:0], "R11 read");

        // R1, R4: high mask bank1 bit3, event there
        step(0, 0, 1, 4'b0101, 32'h8, "R3 mask write");
        rd(4'b0101, "R3 mask readback");
        step(1, {2'd1, 5'd3}, 0, 0, 0, "R4 hi raised");
        chk("R4 irq_hi up", {31'b0, irq_hi}, 32'h1);
        rd(4'b0001, "R1 pend1");
        // R2: accumulate
        step(1, {2'd1, 5'd7}, 0, 0, 0, "R2 second event");
        rd(4'b0001, "R2 pend1 accum");
        chk("R2 value", reg_rdata, 32'h88);
        // R7: repeated reads unchanged
        rd(4'b0001, "R7 read a");
        @(negedge clk);
        rd(4'b0001, "R7 read b");
        // R5: clear bit 3 only
        step(0, 0, 1, 4'b0001, 32'h8, "R5 clear");
        rd(4'b0001, "R5 pend1 after clear");
        chk("R5 irq_hi down", {31'b0, irq_hi}, 32'h0);

        // R6: two banks enabled, clear one at a time
        step(0, 0, 1, 4'b0100, 32'h1, "R6 mask b0");
        step(0, 0, 1, 4'b0110, 32'h1, "R6 mask b2");
        step(1, {2'd0, 5'd0}, 0, 0, 0, "R6 ev b0");
        step(1, {2'd2, 5'd0}, 0, 0, 0, "R6 ev b2");
        step(0, 0, 1, 4'b0000, 32'hFFFF_FFFF, "R6 clear b0");
        chk("R6 hi held", {31'b0, irq_hi}, 32'h1);
        step(0, 0, 1, 4'b0010, 32'h1, "R6 clear b2");
        chk("R6 hi dropped", {31'b0, irq_hi}, 32'h0);

        // R8: mask alone toggles low line
        step(1, {2'd2, 5'd31}, 0, 0, 0, "R8 ev");
        chk("R8 lo idle", {31'b0, irq_lo}, 32'h0);
        step(0, 0, 1, 4'b1110, 32'h8000_0000, "R8 mask on");
        chk("R8 lo up", {31'b0, irq_lo}, 32'h1);
        step(0, 0, 1, 4'b1110, 32'h0, "R8 mask off");
        chk("R8 lo down", {31'b0, irq_lo}, 32'h0);

        // R9: event and clear on same flag
        step(1, {2'd0, 5'd5}, 1, 4'b0000, 32'hFFFF_FFFF, "R9 race");
        rd(4'b0000, "R9 pend0");
        chk("R9 value", reg_rdata, 32'h20);

        // R10: bank 3 codes ignored
        for (int i = 0; i < 4; i++) begin
            step(1, {2'd3, 5'(i * 9)}, 0, 0, 0, "R10 bank3 event");
            for (int b = 0; b < 3; b++) rd({2'd0, b[1:0]}, "R10 pend unchanged");
        end

        // R3: bank index 3 unmapped
        step(0, 0, 1, 4'b1011, 32'hDEAD_BEEF, "R3 unmapped write");
        for (int g = 0; g < 4; g++) rd({g[1:0], 2'd3}, "R3 unmapped read");
        for (int a = 4; a < 16; a++) rd(a[3:0], "R3 masks intact");

        // random mix, R4/R5/R7 against model
        for (int i = 0; i < 3000; i++) begin
            logic        ev = 1'($urandom_range(0, 1));
            logic [6:0]  cd = 7'($urandom);
            logic        we = ($urandom_range(0, 3) == 0);
            logic [3:0]  ad = 4'($urandom);
            logic [31:0] wd = ($urandom_range(0, 1) == 0) ? $urandom : (32'h1 << $urandom_range(0, 31));
            step(ev, cd, we, ad, wd, "R4 random");
            rd(4'($urandom), "R7 random read");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule